// File: doc/BRIEF.md
# Serial Configuration Port with Staged Commit

This block is a slave serial port that sits between a host controller and a bank of byte-wide setting registers. The host drives a serial clock, a data-in line and an active-low enable. The block answers on a data-out line. Each transfer is a self-framed sequence sampled on falling clock edges. It opens with a low start bit, then carries a direction bit and a five-bit address sent MSB first. A write then carries eight data bits and closes with two high stop bits. A read instead returns the addressed byte on the data-out line.

A completed write does not change the live settings at once. It lands in a staging copy. The whole staging copy moves to the live registers in a single step when the enable is released, so several registers can be changed together in one enable-low window. The address space holds twelve byte slots. Slot 5 is a read-only status byte supplied by the surrounding logic, and the other eleven slots are writable settings. The serial pins are brought into the system clock domain through synchronisers, so the system clock must run at eight or more times the serial clock.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset every live byte on `cfg_live` is 0x00 and `sdo` is 0.
- R2: A write transfer is sampled on falling `sck` edges: a start bit of 0, a direction bit of 0, address bits A4..A0, data bits D7..D0, then two stop bits of 1. The data is staged for the addressed slot, and slot n occupies `cfg_live[8n+7:8n]`.
- R3: Staged data does not reach `cfg_live`, and is not returned by reads, until `en_n` rises. On that rise every staged byte becomes live together.
- R4: Several transfers may follow one another within one enable-low window, each preceded by at least one `sck` period with `sdi` high. All of them take effect at the next rise of `en_n`.
- R5: A read transfer has a direction bit of 1 and then the address. The live byte is then shifted out on `sdo` MSB first. Each bit changes after a rising `sck` edge and is valid at the following falling edge, and the transfer ends after eight data bits.
- R6: A read of address 5 returns the current value of `status_in`.
- R7: Writes to address 5 or to any address of 12 or above are discarded. Reads of addresses 12 and above return 0x00, and `cfg_live` slot 5 stays 0x00.
- R8: `sdo` is 0 at all times outside the data phase of a read transfer.
- R9: A write whose stop bits are not both 1, or one cut off by `en_n` rising before its stop bits, leaves the staged and live bytes unchanged.
- R10: A start bit is recognised only after `sdi` has been sampled high on at least one falling `sck` edge since the previous transfer ended. A low bit that directly follows a transfer starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle high |
| sdi | input | 1 | Serial data from the host, idle high |
| en_n | input | 1 | Active-low transfer enable; its rising edge commits staged data |
| status_in | input | 8 | Read-only status byte returned at address 5 |
| sdo | output | 1 | Serial read data, 0 outside a read |
| cfg_live | output | 96 | Live settings, slot n in bits 8n+7:8n |

## Verification
Each pin passes through two synchroniser stages and one edge register, and the frame logic then registers its decision. A falling or rising `sck` edge therefore acts about four system clocks after the pin moves. A rise of `en_n` shows on `cfg_live` about four clocks later. The bench holds every serial half-period for eight system clocks, so it samples `sdo` just before the next falling edge, well after the bit has settled. It looks at `cfg_live` twelve clocks after releasing the enable. Before the release it checks that the staged values are not yet visible at the ports.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

   typedef enum logic [2:0] {
      ST_WAIT_HI,
      ST_ARMED,
      ST_RW,
      ST_ADDR,
      ST_DATA,
      ST_STOP,
      ST_READ
   } frame_st_e;

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
   parameter int WIDTH     = 3,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin,
   output logic [WIDTH-1:0] lvl
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL}};
         else        chain <= {chain[STAGES-2:0], pin[i]};
      end
      assign lvl[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
   import cfg_serial_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int STOP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_act,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_strobe,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_active,
   output logic              sdo
);

   localparam int MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int MAXC  = (MAXF > STOP_BITS) ? MAXF : STOP_BITS;
   localparam int CNT_W = $clog2(MAXC) + 1;

   frame_st_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_sh;
   logic [DATA_W-1:0] data_sh;
   logic [DATA_W-1:0] rd_sh;
   logic              is_rd;
   logic              sdo_q;

   assign rd_addr   = {addr_sh[ADDR_W-2:0], sdi};
   assign wr_addr   = addr_sh;
   assign wr_data   = data_sh;
   assign rd_active = (st == ST_READ);
   assign sdo       = sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_WAIT_HI;
         cnt       <= '0;
         addr_sh   <= '0;
         data_sh   <= '0;
         rd_sh     <= '0;
         is_rd     <= 1'b0;
         sdo_q     <= 1'b0;
         wr_strobe <= 1'b0;
      end else begin
         wr_strobe <= 1'b0;
         if (!en_act) begin
            st    <= ST_WAIT_HI;
            sdo_q <= 1'b0;
         end else if (sck_fall) begin
            case (st)
               ST_WAIT_HI: if (sdi) st <= ST_ARMED;
               ST_ARMED:   if (!sdi) st <= ST_RW;
               ST_RW: begin
                  is_rd <= sdi;
                  cnt   <= '0;
                  st    <= ST_ADDR;
               end
               ST_ADDR: begin
                  addr_sh <= {addr_sh[ADDR_W-2:0], sdi};
                  cnt     <= cnt + 1'b1;
                  if (cnt == CNT_W'(ADDR_W-1)) begin
                     cnt <= '0;
                     if (is_rd) begin
                        st    <= ST_READ;
                        rd_sh <= rd_byte;
                     end else begin
                        st <= ST_DATA;
                     end
                  end
               end
               ST_DATA: begin
                  data_sh <= {data_sh[DATA_W-2:0], sdi};
                  cnt     <= cnt + 1'b1;
                  if (cnt == CNT_W'(DATA_W-1)) begin
                     cnt <= '0;
                     st  <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (!sdi) begin
                     st <= ST_WAIT_HI;
                  end else begin
                     cnt <= cnt + 1'b1;
                     if (cnt == CNT_W'(STOP_BITS-1)) begin
                        wr_strobe <= 1'b1;
                        st        <= ST_WAIT_HI;
                     end
                  end
               end
               ST_READ: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(DATA_W-1)) begin
                     st    <= ST_WAIT_HI;
                     sdo_q <= 1'b0;
                  end
               end
               default: st <= ST_WAIT_HI;
            endcase
         end else if (sck_rise && st == ST_READ) begin
            sdo_q <= rd_sh[DATA_W-1];
            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter int NUM_ADDR    = 12,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int STATUS_ADDR = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_strobe,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       commit,
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [DATA_W-1:0]          status_in,
   output logic [DATA_W-1:0]          rd_byte,
   output logic [NUM_ADDR*DATA_W-1:0] live_flat,
   output logic [NUM_ADDR*DATA_W-1:0] shadow_flat
);

   for (genvar a = 0; a < NUM_ADDR; a++) begin : g_slot
      if (a == STATUS_ADDR) begin : g_ro
         assign shadow_flat[a*DATA_W +: DATA_W] = '0;
         assign live_flat[a*DATA_W +: DATA_W]   = '0;
      end else begin : g_rw
         logic [DATA_W-1:0] stage_q;
         logic [DATA_W-1:0] live_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
               live_q  <= '0;
            end else begin
               if (wr_strobe && wr_addr == ADDR_W'(a)) stage_q <= wr_data;
               if (commit) live_q <= stage_q;
            end
         end
         assign shadow_flat[a*DATA_W +: DATA_W] = stage_q;
         assign live_flat[a*DATA_W +: DATA_W]   = live_q;
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int a = 0; a < NUM_ADDR; a++) begin
         if (rd_addr == ADDR_W'(a)) begin
            rd_byte = (a == STATUS_ADDR) ? status_in : live_flat[a*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
   parameter int NUM_ADDR    = 12,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int STATUS_ADDR = 5,
   parameter int STOP_BITS   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sck,
   input  logic                       sdi,
   input  logic                       en_n,
   input  logic [DATA_W-1:0]          status_in,
   output logic                       sdo,
   output logic [NUM_ADDR*DATA_W-1:0] cfg_live
);

   localparam int LIVE_W = NUM_ADDR * DATA_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STATUS_ADDR >= NUM_ADDR) begin : g_bad_status
      $error("STATUS_ADDR must lie inside the address map");
   end
   if (NUM_ADDR > (1 << ADDR_W)) begin : g_bad_map
      $error("NUM_ADDR exceeds the address width");
   end
   if (STOP_BITS < 1 || ADDR_W < 2 || DATA_W < 2) begin : g_bad_frame
      $error("frame field widths too small");
   end

   logic [2:0] pin_lvl;
   logic       sck_lvl, sdi_lvl, en_lvl;
   logic       sck_last, en_last;
   logic       sck_rise, sck_fall, en_rise;

   cfg_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   ({en_n, sdi, sck}),
      .lvl   (pin_lvl)
   );

   assign sck_lvl = pin_lvl[0];
   assign sdi_lvl = pin_lvl[1];
   assign en_lvl  = pin_lvl[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_last <= 1'b1;
         en_last  <= 1'b1;
      end else begin
         sck_last <= sck_lvl;
         en_last  <= en_lvl;
      end
   end

   assign sck_rise = sck_lvl & ~sck_last;
   assign sck_fall = ~sck_lvl & sck_last;
   assign en_rise  = en_lvl & ~en_last;

   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_byte, wr_data;
   logic              wr_strobe, rd_active;
   logic [LIVE_W-1:0] shadow_flat;

   cfg_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_act    (~en_lvl),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .sdi       (sdi_lvl),
      .rd_byte   (rd_byte),
      .rd_addr   (rd_addr),
      .wr_strobe (wr_strobe),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_active (rd_active),
      .sdo       (sdo)
   );

   cfg_reg_bank #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .STATUS_ADDR(STATUS_ADDR)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_strobe   (wr_strobe),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .commit      (en_rise),
      .rd_addr     (rd_addr),
      .status_in   (status_in),
      .rd_byte     (rd_byte),
      .live_flat   (cfg_live),
      .shadow_flat (shadow_flat)
   );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int W = 96
) (
   input logic         clk,
   input logic         rst_n,
   input logic         commit,
   input logic         en_hi,
   input logic         wr_strobe,
   input logic         rd_active,
   input logic         sdo,
   input logic [W-1:0] cfg_live,
   input logic [W-1:0] shadow
);

   // R8: data-out stays low unless a read data phase is running
   a_r8_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active |-> !sdo);

   // R8: a released enable ends any read in progress
   a_r8_read_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      en_hi |=> !rd_active);

   // R3: live settings only move on a commit
   a_r3_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cfg_live));

   // R3: a commit copies the whole staging image
   a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> cfg_live == $past(shadow));

   // R9: staging changes only on a completed write
   a_r9_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe |=> $stable(shadow));

   // R2: one completed write yields a single-cycle strobe
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);

endmodule

bind cfg_serial_port cfg_serial_port_chk #(.W(NUM_ADDR*DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .commit    (en_rise),
   .en_hi     (en_lvl),
   .wr_strobe (wr_strobe),
   .rd_active (rd_active),
   .sdo       (sdo),
   .cfg_live  (cfg_live),
   .shadow    (shadow_flat)
);

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;

   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b1;
   logic        sdi = 1'b1;
   logic        en_n = 1'b1;
   logic [7:0]  status_in = 8'h96;
   logic        sdo;
   logic [95:0] cfg_live;

   int checks = 0;
   int errors = 0;
   int sdo_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cfg_serial_port u0 (
      .clk (clk), .rst_n (rst_n), .sck (sck), .sdi (sdi), .en_n (en_n),
      .status_in (status_in), .sdo (sdo), .cfg_live (cfg_live)
   );

   typedef struct packed {
      logic [4:0] a;
      logic [7:0] d;
      logic [7:0] e;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{a: 5'd0,  d: 8'hA5, e: 8'hA5},
      '{a: 5'd1,  d: 8'h3C, e: 8'h3C},
      '{a: 5'd4,  d: 8'h81, e: 8'h81},
      '{a: 5'd6,  d: 8'h7E, e: 8'h7E},
      '{a: 5'd8,  d: 8'h01, e: 8'h01},
      '{a: 5'd5,  d: 8'hFF, e: 8'h96},
      '{a: 5'd14, d: 8'h55, e: 8'h00},
      '{a: 5'd11, d: 8'hC3, e: 8'hC3}
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] live_byte(input int a);
      return cfg_live[a*8 +: 8];
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_tx(input logic b);
      sdi = b;
      wait_clk(H);
      if (sdo !== 1'b0) sdo_bad++;
      sck = 1'b0;
      wait_clk(H);
      sck = 1'b1;
   endtask

   task automatic write_frame(input logic [4:0] a, input logic [7:0] d,
                              input logic [1:0] stops, input bit idle);
      if (idle) bit_tx(1'b1);
      bit_tx(1'b0);
      bit_tx(1'b0);
      for (int i = 4; i >= 0; i--) bit_tx(a[i]);
      for (int i = 7; i >= 0; i--) bit_tx(d[i]);
      bit_tx(stops[1]);
      bit_tx(stops[0]);
   endtask

   task automatic read_frame(input logic [4:0] a, output logic [7:0] d);
      d = '0;
      bit_tx(1'b1);
      bit_tx(1'b0);
      bit_tx(1'b1);
      for (int i = 4; i >= 0; i--) bit_tx(a[i]);
      for (int i = 0; i < 8; i++) begin
         sdi = 1'b1;
         wait_clk(H);
         d = {d[6:0], sdo};
         sck = 1'b0;
         wait_clk(H);
         sck = 1'b1;
      end
   endtask

   task automatic open_window();
      en_n = 1'b0;
      wait_clk(6);
   endtask

   task automatic close_window();
      en_n = 1'b1;
      wait_clk(12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R1: reset state
      for (int a = 0; a < 12; a++) check8("R1 live byte", live_byte(a), 8'h00);
      check8("R1 sdo", {7'd0, sdo}, 8'h00);

      // R2 / R4: table of writes in one enable-low window
      open_window();
      for (int i = 0; i < 8; i++) write_frame(VEC[i].a, VEC[i].d, 2'b11, 1'b1);
      // R3: staged data not visible yet
      check8("R3 live before commit", live_byte(0), 8'h00);
      read_frame(5'd0, rd);
      check8("R3 read before commit", rd, 8'h00);
      close_window();

      // R5 / R6 / R7: read back every table entry
      open_window();
      for (int i = 0; i < 8; i++) begin
         read_frame(VEC[i].a, rd);
         check8("R5 readback", rd, VEC[i].e);
         if (VEC[i].a < 12 && VEC[i].a != 5)
            check8("R2 live slot", live_byte(int'(VEC[i].a)), VEC[i].e);
      end
      close_window();
      check8("R4 last frame of window", live_byte(11), 8'hC3);
      check8("R7 status slot live", live_byte(5), 8'h00);

      // R6: status follows the input
      status_in = 8'h5A;
      open_window();
      read_frame(5'd5, rd);
      check8("R6 status read", rd, 8'h5A);
      read_frame(5'd13, rd);
      check8("R7 unmapped read", rd, 8'h00);
      close_window();

      // R9: bad second stop bit
      open_window();
      write_frame(5'd1, 8'h11, 2'b10, 1'b1);
      close_window();
      check8("R9 bad stop", live_byte(1), 8'h3C);

      // R9: frame cut by enable release
      open_window();
      bit_tx(1'b1);
      bit_tx(1'b0);
      bit_tx(1'b0);
      for (int i = 4; i >= 0; i--) bit_tx(5'd4 >> i);
      for (int i = 0; i < 6; i++) bit_tx(1'b0);
      close_window();
      check8("R9 cut frame", live_byte(4), 8'h81);

      // R10: frame with no idle bit before it is ignored
      open_window();
      write_frame(5'd6, 8'h99, 2'b11, 1'b1);
      write_frame(5'd0, 8'hFF, 2'b11, 1'b0);
      close_window();
      check8("R2 write before back-to-back", live_byte(6), 8'h99);
      check8("R10 no start without idle", live_byte(0), 8'hA5);

      // R8: sdo low outside read data phases
      check8("R8 sdo idle samples", sdo_bad[7:0], 8'h00);
      check8("R8 sdo final", {7'd0, sdo}, 8'h00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule